// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block moves 36-bit words in one direction, from a producer in one clock domain to a consumer in another. The two clocks may be unrelated or may be the same clock. Each side has an active-low select and an active-high enable, and a transfer happens only when both agree on a rising edge of that side's clock. Pointers cross between the domains in Gray code through a chain of synchronizer flops. A flag therefore goes active as soon as its own side causes the change, and clears only after the other side's pointer has crossed over.

Each side has one status pin and one active-low level-warning pin. The read-side warning goes low when few words are stored. The write-side warning goes low when little room is left. Each threshold is a register that is loaded from an input bus while reset is held. A static mode input picks one of two read timings. In the standard timing, the status pins report empty and full, and a read request fetches the next word. In the fall-through timing, the first word moves to the output on its own. The read status then means "a word is waiting" and the write status means "room is available".

Top module: `async_flag_fifo`

## Requirements
- R1: A word is written on a rising `wr_clk` edge only when `wr_cs_n` is 0 and `wr_en` is 1. A word is read on a rising `rd_clk` edge only when `rd_cs_n` is 0 and `rd_en` is 1. A gated read leaves `rd_data` unchanged and consumes no word.
- R2: A write attempted while the write side sees a full memory (2^ADDR_W words held) is dropped, and the stored words are unchanged.
- R3: A read attempted while the memory is empty, in standard timing, is dropped. `rd_data` keeps its value.
- R4: Words leave in the order they were written, with all 36 bits intact.
- R5: In standard timing (`mode_std`=1), `rd_status`=1 means empty and `wr_status`=1 means full. `rd_data` takes the fetched word on the same `rd_clk` edge that accepts the read.
- R6: In fall-through timing (`mode_std`=0), the oldest word appears on `rd_data` with no read request, and `rd_status`=1 while it is there. A read removes that word and presents the next one. `wr_status`=1 while the memory has room. The output register adds one word of capacity, so the FIFO holds 2^ADDR_W+1 words.
- R7: `rd_aempty_n` is 0 exactly when the word count is less than or equal to the almost-empty threshold. In fall-through timing the count includes the word held on the output.
- R8: `wr_afull_n` is 0 exactly when the free memory locations are less than or equal to the almost-full threshold.
- R9: The thresholds are loaded from `ae_ofs_in` and `af_ofs_in` on clock edges while `rst_n` is 0. After reset, changes on those inputs have no effect.
- R10: Reset clears both pointers. Right after reset, the FIFO reports empty in standard timing (`rd_status`=1, `wr_status`=0) and no word waiting with room available in fall-through timing (`rd_status`=0, `wr_status`=1). `rd_aempty_n` is 0, and `wr_afull_n` is 1 for any threshold below 2^ADDR_W.
- R11: A flag caused by a side's own transfer is visible right after that edge. A flag change caused by the other side settles within a few edges of the observing clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset for both sides; thresholds load while it is low |
| mode_std | input | 1 | 1 = standard timing, 0 = fall-through timing; static |
| ae_ofs_in | input | ADDR_W+1 | Almost-empty threshold, loaded during reset |
| af_ofs_in | input | ADDR_W+1 | Almost-full threshold, loaded during reset |
| wr_cs_n | input | 1 | Write select, active low |
| wr_en | input | 1 | Write enable |
| wr_data | input | DATA_W | Write data |
| wr_status | output | 1 | Full (standard) or room available (fall-through) |
| wr_afull_n | output | 1 | Almost-full warning, active low |
| rd_cs_n | input | 1 | Read select, active low |
| rd_en | input | 1 | Read enable |
| rd_data | output | DATA_W | Read data register |
| rd_status | output | 1 | Empty (standard) or word waiting (fall-through) |
| rd_aempty_n | output | 1 | Almost-empty warning, active low |

## Verification
On every cycle, the assertions check the following:
- a full memory freezes the write pointer and an empty one freezes the read pointer;
- a gated port moves no pointer and changes no data;
- pointers step by at most one;
- the write-side count never passes the depth;
- a waiting fall-through word is held until it is read.

The bench's scenarios cover the rest. They show the threshold comparisons at every fill level, the exact word order and data bits, and the extra output word of capacity in fall-through timing. They also show that thresholds changed after reset are ignored, and that a flag raised by its own side appears at once.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  typedef logic [31:0] word32_t;

  // binary to reflected Gray code
  function automatic word32_t to_gray(word32_t b);
    return b ^ (b >> 1);
  endfunction

  // Gray code back to binary by prefix XOR from the top bit down
  function automatic word32_t from_gray(word32_t g);
    word32_t b;
    b = g;
    b = b ^ (b >> 1);
    b = b ^ (b >> 2);
    b = b ^ (b >> 4);
    b = b ^ (b >> 8);
    b = b ^ (b >> 16);
    return b;
  endfunction

  // distance from b up to a, modulo 2^w (w below 32)
  function automatic word32_t span(word32_t a, word32_t b, int unsigned w);
    return (a - b) & ((32'h1 << w) - 32'h1);
  endfunction

  // level test shared by both warning flags
  function automatic logic within_ofs(word32_t level, word32_t ofs);
    return level <= ofs;
  endfunction

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES > 1) begin : g_chain
      logic [STAGES*W-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[(STAGES-1)*W-1:0], d};
      end
      assign q = chain[STAGES*W-1 -: W];
    end else begin : g_single
      logic [W-1:0] stage;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= d;
      end
      assign q = stage;
    end
  endgenerate

endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  // read is registered by the read controller
  assign rdata = cells[raddr];

endmodule

// File: rtl/afifo_wr_ctl.sv
module afifo_wr_ctl
  import afifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            en,
  input  logic            mode_std,
  input  logic [ADDR_W:0] af_ofs_in,
  input  logic [ADDR_W:0] rptr_gray_s,
  output logic [ADDR_W:0] wptr_gray,
  output logic [ADDR_W-1:0] waddr,
  output logic            push,
  output logic            status,
  output logic            afull_n
);

  localparam int CNT_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [CNT_W-1:0] wptr_bin;
  logic [CNT_W-1:0] wptr_next;
  logic [CNT_W-1:0] rptr_bin_s;
  logic [CNT_W-1:0] used;
  logic [CNT_W-1:0] af_ofs;
  logic             full;
  word32_t          free_slots;

  assign rptr_bin_s = CNT_W'(from_gray(32'(rptr_gray_s)));
  assign used       = CNT_W'(span(32'(wptr_bin), 32'(rptr_bin_s), CNT_W));
  assign full       = (used == CNT_W'(DEPTH));
  assign free_slots = 32'(DEPTH) - 32'(used);
  assign push       = !cs_n && en && !full;
  assign wptr_next  = wptr_bin + 1'b1;
  assign waddr      = wptr_bin[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
    end else if (push) begin
      wptr_bin  <= wptr_next;
      wptr_gray <= CNT_W'(to_gray(32'(wptr_next)));
    end
  end

  // threshold loads on clock edges during reset only
  always_ff @(posedge clk) begin
    if (!rst_n) af_ofs <= af_ofs_in;
  end

  assign status  = mode_std ? full : !full;
  assign afull_n = !within_ofs(free_slots, 32'(af_ofs));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(wptr_bin));

  assert_wr_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !en) |=> $stable(wptr_bin));

  assert_wr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (CNT_W'(wptr_bin - $past(wptr_bin)) <= CNT_W'(1)));

  assert_wr_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    used <= CNT_W'(DEPTH));

endmodule

// File: rtl/afifo_rd_ctl.sv
module afifo_rd_ctl
  import afifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              en,
  input  logic              mode_std,
  input  logic [ADDR_W:0]   ae_ofs_in,
  input  logic [ADDR_W:0]   wptr_gray_s,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W:0]   rptr_gray,
  output logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rd_data,
  output logic              status,
  output logic              aempty_n
);

  localparam int CNT_W = ADDR_W + 1;

  logic [CNT_W-1:0] rptr_bin;
  logic [CNT_W-1:0] rptr_next;
  logic [CNT_W-1:0] wptr_bin_s;
  logic [CNT_W-1:0] stored;
  logic [CNT_W-1:0] ae_ofs;
  logic             mem_empty;
  logic             rd_req;
  logic             out_vld;
  logic             pop;
  logic             fetch;
  word32_t          level;

  assign wptr_bin_s = CNT_W'(from_gray(32'(wptr_gray_s)));
  assign stored     = CNT_W'(span(32'(wptr_bin_s), 32'(rptr_bin), CNT_W));
  assign mem_empty  = (stored == '0);
  assign rd_req     = !cs_n && en;
  assign pop        = !mode_std && rd_req && out_vld;
  assign fetch      = !mem_empty && (mode_std ? rd_req : (!out_vld || pop));
  assign rptr_next  = rptr_bin + 1'b1;
  assign raddr      = rptr_bin[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
      rd_data   <= '0;
      out_vld   <= 1'b0;
    end else if (fetch) begin
      rptr_bin  <= rptr_next;
      rptr_gray <= CNT_W'(to_gray(32'(rptr_next)));
      rd_data   <= mem_rdata;
      out_vld   <= 1'b1;
    end else if (pop) begin
      out_vld   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ae_ofs <= ae_ofs_in;
  end

  // fall-through count includes the word parked on the output
  assign level    = 32'(stored) + ((!mode_std && out_vld) ? 32'd1 : 32'd0);
  assign status   = mode_std ? mem_empty : out_vld;
  assign aempty_n = !within_ofs(level, 32'(ae_ofs));

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_empty |=> $stable(rptr_bin));

  assert_rd_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_n || !en) && (mode_std || out_vld)) |=> ($stable(rd_data) && $stable(rptr_bin)));

  assert_ft_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_std && out_vld && !rd_req) |=> out_vld);

  assert_rd_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (CNT_W'(rptr_bin - $past(rptr_bin)) <= CNT_W'(1)));

endmodule

// File: rtl/async_flag_fifo.sv
module async_flag_fifo #(
  parameter int DATA_W      = 36,
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              mode_std,
  input  logic [ADDR_W:0]   ae_ofs_in,
  input  logic [ADDR_W:0]   af_ofs_in,
  input  logic              wr_cs_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_status,
  output logic              wr_afull_n,
  input  logic              rd_cs_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_status,
  output logic              rd_aempty_n
);

  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0]  wptr_gray, wptr_gray_s;
  logic [PTR_W-1:0]  rptr_gray, rptr_gray_s;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              push;
  logic [DATA_W-1:0] mem_rdata;

  afifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .cs_n(wr_cs_n), .en(wr_en),
    .mode_std(mode_std), .af_ofs_in(af_ofs_in), .rptr_gray_s(rptr_gray_s),
    .wptr_gray(wptr_gray), .waddr(waddr), .push(push),
    .status(wr_status), .afull_n(wr_afull_n)
  );

  afifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk(wr_clk), .we(push), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata)
  );

  afifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wptr_gray), .q(wptr_gray_s)
  );

  afifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rptr_gray), .q(rptr_gray_s)
  );

  afifo_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .cs_n(rd_cs_n), .en(rd_en),
    .mode_std(mode_std), .ae_ofs_in(ae_ofs_in), .wptr_gray_s(wptr_gray_s),
    .mem_rdata(mem_rdata), .rptr_gray(rptr_gray), .raddr(raddr),
    .rd_data(rd_data), .status(rd_status), .aempty_n(rd_aempty_n)
  );

endmodule

// File: tb/async_flag_fifo_tb.sv
module async_flag_fifo_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD + 4;
  localparam int DATA_W     = 36;
  localparam int ADDR_W     = 4;
  localparam int DEPTH      = 1 << ADDR_W;

  logic              wr_clk = 1'b0;
  logic              rd_clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mode_std = 1'b1;
  logic [ADDR_W:0]   ae_ofs_in = '0;
  logic [ADDR_W:0]   af_ofs_in = '0;
  logic              wr_cs_n = 1'b1;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              wr_status, wr_afull_n;
  logic              rd_cs_n = 1'b1;
  logic              rd_en = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_status, rd_aempty_n;

  int n_checks = 0;
  int n_fail   = 0;

  async_flag_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .mode_std(mode_std),
    .ae_ofs_in(ae_ofs_in), .af_ofs_in(af_ofs_in),
    .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_status(wr_status), .wr_afull_n(wr_afull_n),
    .rd_cs_n(rd_cs_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_status(rd_status), .rd_aempty_n(rd_aempty_n)
  );

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  function automatic logic [DATA_W-1:0] pat(int k, int salt);
    return DATA_W'(k) * 36'h1_2345_6789 ^ DATA_W'(salt) * 36'h9_0F0F_0F0F;
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr_word(logic [DATA_W-1:0] d, logic cs_n, logic en);
    @(negedge wr_clk);
    wr_cs_n = cs_n; wr_en = en; wr_data = d;
    @(negedge wr_clk);
    wr_cs_n = 1'b1; wr_en = 1'b0;
  endtask

  task automatic rd_word(logic cs_n, logic en);
    @(negedge rd_clk);
    rd_cs_n = cs_n; rd_en = en;
    @(negedge rd_clk);
    rd_cs_n = 1'b1; rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic do_reset(logic m, int ae, int af);
    rst_n = 1'b0;
    mode_std = m;
    ae_ofs_in = (ADDR_W+1)'(ae);
    af_ofs_in = (ADDR_W+1)'(af);
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk);
    rst_n = 1'b1;
    // R9: values presented after reset must be ignored
    ae_ofs_in = '0;
    af_ofs_in = (ADDR_W+1)'(DEPTH - 1);
    settle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    // ---------------- standard timing, ae=3, af=2 ----------------
    do_reset(1'b1, 3, 2);
    chk("R10 std rd_status", 64'(rd_status), 64'd1);
    chk("R10 std wr_status", 64'(wr_status), 64'd0);
    chk("R10 std aempty_n", 64'(rd_aempty_n), 64'd0);
    chk("R10 std afull_n", 64'(wr_afull_n), 64'd1);

    // R1: gated writes
    wr_word(pat(99, 0), 1'b1, 1'b1);
    wr_word(pat(98, 0), 1'b0, 1'b0);
    settle();
    chk("R1 gated write leaves empty", 64'(rd_status), 64'd1);

    // R3: read on empty
    rd_word(1'b0, 1'b1);
    chk("R3 empty read keeps data", 64'(rd_data), 64'd0);
    chk("R3 empty read keeps empty", 64'(rd_status), 64'd1);

    for (int k = 1; k <= DEPTH; k++) begin
      wr_word(pat(k, 0), 1'b0, 1'b1);
      if (k == DEPTH) chk("R11 full at once", 64'(wr_status), 64'd1);
      settle();
      chk("R7 std aempty_n fill", 64'(rd_aempty_n), 64'(k > 3));
      chk("R8 std afull_n fill", 64'(wr_afull_n), 64'(!((DEPTH - k) <= 2)));
      chk("R5 std full flag", 64'(wr_status), 64'(k == DEPTH));
      chk("R5 std not empty", 64'(rd_status), 64'd0);
    end

    // R2: write into full memory
    wr_word(36'hD_EAD0_BEEF, 1'b0, 1'b1);
    settle();
    chk("R2 still full", 64'(wr_status), 64'd1);

    // R1: gated read
    rd_word(1'b1, 1'b1);
    chk("R1 gated read keeps data", 64'(rd_data), 64'd0);

    for (int k = 1; k <= DEPTH; k++) begin
      rd_word(1'b0, 1'b1);
      chk("R4 std order", 64'(rd_data), 64'(pat(k, 0)));
      if (k == DEPTH) chk("R11 empty at once", 64'(rd_status), 64'd1);
      settle();
      chk("R7 std aempty_n drain", 64'(rd_aempty_n), 64'((DEPTH - k) > 3));
      chk("R8 std afull_n drain", 64'(wr_afull_n), 64'(k > 2));
      chk("R5 std empty flag", 64'(rd_status), 64'(k == DEPTH));
      chk("R5 std full clear", 64'(wr_status), 64'd0);
    end

    rd_word(1'b0, 1'b1);
    chk("R3 underflow keeps last", 64'(rd_data), 64'(pat(DEPTH, 0)));

    // ---------------- fall-through timing, ae=1, af=4 ----------------
    do_reset(1'b0, 1, 4);
    chk("R10 ft rd_status", 64'(rd_status), 64'd0);
    chk("R10 ft wr_status", 64'(wr_status), 64'd1);
    chk("R10 ft aempty_n", 64'(rd_aempty_n), 64'd0);
    chk("R10 ft afull_n", 64'(wr_afull_n), 64'd1);

    for (int k = 1; k <= DEPTH + 1; k++) begin
      wr_word(pat(k, 1), 1'b0, 1'b1);
      settle();
      chk("R6 ft word waiting", 64'(rd_status), 64'd1);
      chk("R6 ft head presented", 64'(rd_data), 64'(pat(1, 1)));
      chk("R7 ft aempty_n fill", 64'(rd_aempty_n), 64'(k > 1));
      chk("R8 ft afull_n fill", 64'(wr_afull_n), 64'(!((DEPTH + 1 - k) <= 4)));
      chk("R6 ft room flag", 64'(wr_status), 64'(k < DEPTH + 1));
    end

    // R2: extra write while no room
    wr_word(36'hB_AD00_0001, 1'b0, 1'b1);
    settle();

    for (int k = 1; k <= DEPTH + 1; k++) begin
      int rem;
      int memcnt;
      chk("R4 ft order", 64'(rd_data), 64'(pat(k, 1)));
      rd_word(1'b0, 1'b1);
      settle();
      rem = DEPTH + 1 - k;
      memcnt = (rem > 0) ? rem - 1 : 0;
      chk("R6 ft waiting after pop", 64'(rd_status), 64'(rem > 0));
      chk("R7 ft aempty_n drain", 64'(rd_aempty_n), 64'(rem > 1));
      chk("R8 ft afull_n drain", 64'(wr_afull_n), 64'(!((DEPTH - memcnt) <= 4)));
      chk("R6 ft room after pop", 64'(wr_status), 64'd1);
    end
    chk("R2 dropped word absent", 64'(rd_status), 64'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule